// File: doc/BRIEF.md
# Serial-Loaded Coefficient Row Store

This block keeps 32 rows of filter coefficients, four signed 11-bit values per row, one for each multiplier of a four-tap multiply-accumulate array. A host writes rows over a slow three-wire serial port: a serial clock, a serial data line and an active-low serial enable. Each write is a 64-bit frame that names the row and carries all four of its coefficients. The four values of a row change together, and only once the whole frame has arrived.

The serial wires are asynchronous to the main clock. They are synchronised into the main clock domain, and the rising edge of the serial clock is found there by an edge detector. The serial clock must therefore be several main-clock periods long. On the read side, a 5-bit row address register with an active-low load enable picks the row. The four coefficients of that row are registered onto a 44-bit output that feeds the multiplier coefficient inputs.

A one-cycle write strobe and the index of the row just written are brought out, so that each committed frame can be observed.

Top module: `coef_row_store`

## Requirements
- R1: During and after reset every row holds zero, `coef_out` is zero, `wr_stb` is low and the frame bit count is zero.
- R2: A bit is taken from `ser_din` only on a rising edge of `ser_clk` while `ser_en_n` is low. Serial clock edges while `ser_en_n` is high neither add bits nor change any row.
- R3: A frame is 64 bits sent most significant bit first, frame bit 63 first. Bits 63:59 give the row. Coefficient 4 is taken from bits 58:48, coefficient 3 from bits 42:32, coefficient 2 from bits 26:16 and coefficient 1 from bits 10:0. Bits 47:43, 31:27 and 15:11 are ignored. On `coef_out`, coefficient 1 sits at [10:0], coefficient 2 at [21:11], coefficient 3 at [32:22] and coefficient 4 at [43:33].
- R4: The addressed row is written in full only when the 64th bit has been taken. Until then the row keeps its old value. At the commit `wr_stb` is high for exactly one clock with `wr_row` naming the row, and the bit count returns to zero.
- R5: With `ser_en_n` held low, frames may follow one another with no gap, and each one commits on its own.
- R6: After reset no bit is taken until `ser_en_n` has been seen high and then low. A stream sent with the enable held low from reset onwards writes nothing.
- R7: The read row register loads `rd_row` on a clock edge only when `rd_load_n` is low. `coef_out` shows the newly addressed row one clock edge after the register loads. While the register holds, `coef_out` changes only when its row is written, and then one clock after the commit.
- R8: Raising `ser_en_n` in the middle of a frame freezes the bit count. Once the enable goes low again, the frame carries on from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ser_clk | input | 1 | Serial clock; bits taken on its rising edge |
| ser_din | input | 1 | Serial data, frame MSB first |
| ser_en_n | input | 1 | Active-low serial enable |
| rd_row | input | 5 | Row to read |
| rd_load_n | input | 1 | Active-low load enable of the read row register |
| coef_out | output | 44 | Four coefficients of the selected row |
| wr_stb | output | 1 | One-clock pulse when a frame commits |
| wr_row | output | 5 | Row written by the last commit |

## Verification
A bit counter that has slipped by even one position rotates every later frame. The fault shows at the next commit: `wr_stb` arrives one serial bit early or late, and `wr_row` and the coefficients read back are shifted mixes of neighbouring fields. A wrong arming state shows within one frame, either as a commit after reset with no enable toggle or as a missing commit after a proper toggle. A stale read register or a missed write shows on `coef_out` two clocks after the load, or one clock after the strobe of the selected row.

// File: rtl/coef_row_store.sv
module coef_row_store #(
  parameter int ROWS   = 32,
  parameter int CW     = 11,
  parameter int NC     = 4,
  parameter int WORD_W = 16,
  localparam int AW    = $clog2(ROWS),
  localparam int FRAME = NC * WORD_W,
  localparam int BIT_W = $clog2(FRAME),
  localparam int OW    = NC * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_din,
  input  logic          ser_en_n,
  input  logic [AW-1:0] rd_row,
  input  logic          rd_load_n,
  output logic [OW-1:0] coef_out,
  output logic          wr_stb,
  output logic [AW-1:0] wr_row
);

  logic [2:0]       sclk_q;
  logic [1:0]       sdin_q;
  logic [1:0]       sen_q;
  logic             sen_d;
  logic             armed;
  logic [BIT_W-1:0] bit_cnt;
  logic [FRAME-2:0] shreg;
  logic [OW-1:0]    mem [ROWS];
  logic [AW-1:0]    addr_q;
  logic [OW-1:0]    new_vec;

  wire sen_s     = sen_q[1];
  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire shift     = sclk_rise & armed & ~sen_s;
  wire last_bit  = shift && (bit_cnt == BIT_W'(FRAME - 1));

  wire [FRAME-1:0] frame   = {shreg, sdin_q[1]};
  wire [AW-1:0]    new_row = frame[FRAME-1 -: AW];

  for (genvar k = 0; k < NC; k++) begin : g_field
    assign new_vec[k*CW +: CW] = frame[k*WORD_W +: CW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '0;
      sdin_q <= '0;
      sen_q  <= '0;
      sen_d  <= 1'b0;
      armed  <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[1:0], ser_clk};
      sdin_q <= {sdin_q[0], ser_din};
      sen_q  <= {sen_q[0], ser_en_n};
      sen_d  <= sen_s;
      if (sen_s)      armed <= 1'b0;
      else if (sen_d) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      wr_stb  <= 1'b0;
      wr_row  <= '0;
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else begin
      wr_stb <= last_bit;
      if (shift) begin
        shreg   <= frame[FRAME-2:0];
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      end
      if (last_bit) begin
        mem[new_row] <= new_vec;
        wr_row       <= new_row;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      coef_out <= '0;
    end else begin
      if (!rd_load_n) addr_q <= rd_row;
      coef_out <= mem[addr_q];
    end
  end

endmodule

// File: rtl/coef_row_store_chk.sv
module coef_row_store_chk #(
  parameter int OW = 44,
  parameter int BW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_load_n,
  input logic          wr_stb,
  input logic [OW-1:0] coef_out,
  input logic          sen_s,
  input logic          armed,
  input logic [BW-1:0] bit_cnt
);

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (bit_cnt == '0));

  p_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sen_s |=> $stable(bit_cnt));

  p_unarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(bit_cnt));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_load_n, 2) && !$past(wr_stb)) |-> $stable(coef_out));

  always_comb begin
    if (!rst_n) p_reset_r1: assert (bit_cnt == '0 || $isunknown(bit_cnt));
  end

endmodule

bind coef_row_store coef_row_store_chk #(.OW(OW), .BW(BIT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_load_n(rd_load_n),
  .wr_stb   (wr_stb),
  .coef_out (coef_out),
  .sen_s    (sen_s),
  .armed    (armed),
  .bit_cnt  (bit_cnt)
);

// File: tb/coef_row_store_tb.sv
module coef_row_store_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_din = 1'b0, ser_en_n = 1'b0;
  logic [4:0]  rd_row = '0;
  logic        rd_load_n = 1'b1;
  logic [43:0] coef_out;
  logic        wr_stb;
  logic [4:0]  wr_row;

  int n_chk = 0, n_err = 0, stb_cnt = 0;
  logic [4:0]  last_row = '0;
  logic [43:0] exp_mem [32];
  bit done = 0;

  always #10 clk = ~clk;

  coef_row_store dut_i (.*);

  always @(posedge clk) if (rst_n && wr_stb) begin stb_cnt++; last_row = wr_row; end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin n_err++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  function automatic logic [63:0] mk(input logic [4:0] r, input logic [43:0] v, input logic [63:0] junk);
    logic [63:0] f = junk;
    for (int k = 0; k < 4; k++) f[k*16 +: 11] = v[k*11 +: 11];
    f[63:59] = r;
    return f;
  endfunction

  task automatic ser_bit(input logic b);
    @(negedge clk) ser_din = b;
    repeat (2) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send(input logic [63:0] f, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) ser_bit(f[i]);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_en(input logic v);
    @(negedge clk) ser_en_n = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_row(input logic [4:0] r, output logic [43:0] v);
    @(negedge clk) begin rd_row = r; rd_load_n = 1'b0; end
    @(negedge clk) rd_load_n = 1'b1;
    @(negedge clk) v = coef_out;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [43:0] v, v2, old;
    logic [63:0] f;
    int s0, cur, other;
    void'($urandom(32'h5eed));
    for (int r = 0; r < 32; r++) exp_mem[r] = '0;
    repeat (5) @(negedge clk);
    chk(coef_out == 0 && wr_stb == 0, "R1 outputs in reset", {coef_out, wr_stb}, 0);
    rst_n = 1'b1;
    read_row(5'd31, v);
    chk(v == 0, "R1 row 31 cleared", v, 0);

    // R6: enable low since reset, no falling edge seen
    send(mk(5'd3, 44'h123_4567_89AB, '1), 63, 0);
    chk(stb_cnt == 0, "R6 no commit before arming", stb_cnt, 0);
    read_row(5'd3, v);
    chk(v == 0, "R6 row untouched", v, 0);

    // R3: directed frame, ignored bits all ones
    set_en(1'b1); set_en(1'b0);
    v = {11'h7FF, 11'h401, 11'h0F1, 11'h3A5};
    send(mk(5'd2, v, '1), 63, 0);
    exp_mem[2] = v;
    chk(stb_cnt == 1 && last_row == 2, "R3 commit strobe and row", {stb_cnt, last_row}, {32'd1, 5'd2});
    read_row(5'd2, v2);
    chk(v2 == v, "R3 field placement", v2, v);

    // R4 partial frame, then R8 pause with R2 clocks while disabled
    v = {11'h015, 11'h62A, 11'h2C3, 11'h1E0};
    f = mk(5'd2, v, 64'h0);
    send(f, 63, 24);
    chk(stb_cnt == 1, "R4 no commit at 40 bits", stb_cnt, 1);
    read_row(5'd2, v2);
    chk(v2 == exp_mem[2], "R4 row keeps old value mid-frame", v2, exp_mem[2]);
    set_en(1'b1);
    for (int i = 0; i < 5; i++) ser_bit(1'($urandom));
    repeat (3) @(negedge clk);
    chk(stb_cnt == 1, "R2 no shift while disabled", stb_cnt, 1);
    set_en(1'b0);
    send(f, 23, 0);
    exp_mem[2] = v;
    chk(stb_cnt == 2 && last_row == 2, "R8 resumed frame commits", {stb_cnt, last_row}, {32'd2, 5'd2});
    read_row(5'd2, v2);
    chk(v2 == v, "R8 resumed frame content", v2, v);

    // R2 whole frame with enable high
    set_en(1'b1);
    send(mk(5'd9, 44'hFFF_FFFF_FFFF, '1), 63, 0);
    chk(stb_cnt == 2, "R2 disabled frame ignored", stb_cnt, 2);
    read_row(5'd9, v2);
    chk(v2 == 0, "R2 row 9 unchanged", v2, 0);

    // R5 back-to-back frames, enable held low
    set_en(1'b0);
    for (int n = 0; n < 24; n++) begin
      logic [4:0] r = 5'($urandom);
      v = {$urandom, $urandom};
      s0 = stb_cnt;
      send(mk(r, v, {$urandom, $urandom}), 63, 0);
      exp_mem[r] = v;
      chk(stb_cnt == s0 + 1 && last_row == r, "R5 streamed commit", {stb_cnt, last_row}, {s0 + 1, r});
    end
    for (int r = 0; r < 32; r++) begin
      read_row(5'(r), v2);
      chk(v2 == exp_mem[r], "R5 row readback", v2, exp_mem[r]);
    end

    // R7 hold, timing, and write tracking
    cur = 31;
    other = 0;
    for (int r = 0; r < 31; r++) if (exp_mem[r] != exp_mem[31]) other = r;
    if (exp_mem[other] == exp_mem[31]) begin
      set_en(1'b1); set_en(1'b0);
      exp_mem[0] = ~exp_mem[31];
      send(mk(5'd0, exp_mem[0], '0), 63, 0);
      other = 0;
    end
    read_row(5'(cur), old);
    @(negedge clk) rd_row = 5'(other);
    repeat (3) @(negedge clk);
    chk(coef_out == old, "R7 no load while enable high", coef_out, old);
    @(negedge clk) rd_load_n = 1'b0;
    @(negedge clk) begin
      rd_load_n = 1'b1;
      chk(coef_out == old, "R7 output one edge after load", coef_out, old);
    end
    @(negedge clk) chk(coef_out == exp_mem[other], "R7 output two edges after load", coef_out, exp_mem[other]);
    v = ~exp_mem[other];
    send(mk(5'(other), v, '0), 63, 0);
    exp_mem[other] = v;
    chk(coef_out == v, "R7 selected row follows write", coef_out, v);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule